// File: doc/BRIEF.md
# SDRAM Command and Clock-Enable Front End

This block sits at the pin edge of an SDRAM-style memory device. On every rising clock edge it samples the active-low chip-select, row-strobe, column-strobe and write-enable pins. It also samples the clock-enable pin. The sampled command is turned into a registered one-hot command vector, which the bank, refresh and data-path logic downstream use to start work. A set bit means that command was accepted at the edge just past. An all-zero vector means no command was accepted.

The clock-enable pin is folded into a small power state held in a register. While the device is active, a low clock-enable suspends the internal clock from the next cycle. If the bank logic reports any open bank, the device goes to a plain clock suspend that freezes the output and burst-address state. If every bank is idle, it goes to power-down instead. The device stays in either state until clock-enable is sampled high again. A command on the pins counts only if the power state just before that edge was active, which is the same as clock-enable having been high one edge earlier. Because of this, one rule covers suspend, power-down exit and mode-register loading.

A mode register set arriving while a bank is open is dropped, and a sticky error flag is raised that only reset clears.

Top module: `sdr_cmd_frontend`

## Requirements
- R1: While `clk_en_o` is high, the pins sampled at an edge (cs_n=0) appear on `cmd_o` after that edge, using {ras_n,cas_n,we_n}: 111 gives bit 0 (NOP), 011 bit 1 (activate), 101 bit 2 (read), 100 bit 3 (write), 010 bit 4 (precharge), 001 bit 5 (refresh), 110 bit 6 (burst stop). Each command lasts only one cycle.
- R2: With cs_n high, the other three pins are ignored and the accepted command is NOP (bit 0).
- R3: `cmd_o` never has more than one bit set, and it is all zeros when no command was accepted.
- R4: When clock-enable is sampled low while active and `banks_idle_i` is low, then from the next cycle `clk_en_o` is low, `freeze_o` is high and `pwrdn_o` is low. The command sampled at that same edge is still accepted. A suspended device does not move to power-down even if the banks later become idle.
- R5: While `clk_en_o` is low, all command pins are ignored: `cmd_o` stays zero and `illegal_o` does not change.
- R6: When clock-enable is sampled low while active and `banks_idle_i` is high, `pwrdn_o` and `freeze_o` go high from the next cycle. They stay high while clock-enable stays low, whatever `banks_idle_i` does.
- R7: When clock-enable is sampled high while suspended or powered down, then after that edge `clk_en_o` is high and `freeze_o` and `pwrdn_o` are low. The command at that edge is still ignored, and the command at the following edge is accepted.
- R8: All four command pins low, accepted with `banks_idle_i` high, gives bit 7 (mode register set).
- R9: A mode register set accepted while `banks_idle_i` is low is dropped (`cmd_o` zero) and sets `illegal_o`, which stays high until reset.
- R10: While reset is asserted, `cmd_o` is zero, `illegal_o` is low, `clk_en_o` is high, and `freeze_o` and `pwrdn_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pin clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable pin |
| banks_idle_i | input | 1 | High when every bank is precharged and idle |
| cmd_o | output | 8 | Registered one-hot accepted command |
| clk_en_o | output | 1 | Internal clock enabled (device active) |
| freeze_o | output | 1 | Hold output and burst-address state |
| pwrdn_o | output | 1 | Device in power-down |
| illegal_o | output | 1 | Sticky: mode register set seen with a bank open |

## Verification
The decoder is driven with every strobe pattern under chip-select low, and with a deselect whose strobes would otherwise mean mode register set. This separates real decoding from chip-select masking. Clock-enable is taken low once with a bank open and once with all banks idle, which shows that suspend and power-down are different states. Inside each of these states, strobes and bank status are then changed to show that the inputs are ignored. In each case the exit edge and the edge after it are both checked, which pins down the one-cycle gap before commands are accepted again. A mode register set is sent with banks idle and with a bank open, and is repeated while suspended, to separate acceptance, dropping with the error flag, and being ignored.

// File: rtl/sdfe_pkg.sv
package sdfe_pkg;

  localparam int CMD_W   = 8;
  localparam int CI_NOP  = 0;
  localparam int CI_ACT  = 1;
  localparam int CI_RD   = 2;
  localparam int CI_WR   = 3;
  localparam int CI_PRE  = 4;
  localparam int CI_REF  = 5;
  localparam int CI_BST  = 6;
  localparam int CI_MRS  = 7;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_SUSPEND = 2'd1,
    PS_PDOWN   = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

endpackage

// File: rtl/sdfe_cmd_decode.sv
module sdfe_cmd_decode
  import sdfe_pkg::*;
#(
  parameter int NUM_CMD = CMD_W
) (
  input  pins_t              pins_i,
  output logic [NUM_CMD-1:0] onehot_o
);

  logic [2:0] strobes;
  assign strobes = {pins_i.ras_n, pins_i.cas_n, pins_i.we_n};

  always_comb begin
    onehot_o = '0;
    if (pins_i.cs_n) begin
      onehot_o[CI_NOP] = 1'b1;
    end else begin
      unique case (strobes)
        3'b111:  onehot_o[CI_NOP] = 1'b1;
        3'b011:  onehot_o[CI_ACT] = 1'b1;
        3'b101:  onehot_o[CI_RD]  = 1'b1;
        3'b100:  onehot_o[CI_WR]  = 1'b1;
        3'b010:  onehot_o[CI_PRE] = 1'b1;
        3'b001:  onehot_o[CI_REF] = 1'b1;
        3'b110:  onehot_o[CI_BST] = 1'b1;
        default: onehot_o[CI_MRS] = 1'b1;
      endcase
    end
  end

  // R3: decoder always yields exactly one command
  always_comb begin
    a_r3_decode_onehot: assert ($countones(onehot_o) <= 1);
  end

endmodule

// File: rtl/sdfe_pwr_fsm.sv
module sdfe_pwr_fsm
  import sdfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke_i,
  input  logic       banks_idle_i,
  output pwr_state_e state_o
);

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (cke_i) begin
      state_d = PS_ACTIVE;
    end else if (state_q == PS_ACTIVE) begin
      state_d = banks_idle_i ? PS_PDOWN : PS_SUSPEND;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_ACTIVE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

  a_r4_enter_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ACTIVE && !cke_i && !banks_idle_i) |=> (state_q == PS_SUSPEND));

  a_r6_enter_pdown: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ACTIVE && !cke_i && banks_idle_i) |=> (state_q == PS_PDOWN));

  a_r6_pdown_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_PDOWN && !cke_i) |=> (state_q == PS_PDOWN));

  a_r7_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PS_ACTIVE && cke_i) |=> (state_q == PS_ACTIVE));

endmodule

// File: rtl/sdfe_cmd_stage.sv
module sdfe_cmd_stage
  import sdfe_pkg::*;
#(
  parameter int NUM_CMD = CMD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept_i,
  input  logic               banks_idle_i,
  input  logic [NUM_CMD-1:0] dec_i,
  output logic [NUM_CMD-1:0] cmd_o,
  output logic               illegal_o
);

  logic [NUM_CMD-1:0] cmd_q, cmd_d;
  logic               ill_q, ill_d;
  logic               mrs_blocked;

  assign mrs_blocked = accept_i && dec_i[CI_MRS] && !banks_idle_i;

  always_comb begin
    cmd_d = '0;
    ill_d = ill_q;
    if (accept_i) begin
      cmd_d = dec_i;
    end
    if (mrs_blocked) begin
      cmd_d = '0;
      ill_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      ill_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      ill_q <= ill_d;
    end
  end

  assign cmd_o     = cmd_q;
  assign illegal_o = ill_q;

  a_r3_cmd_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_q));

  a_r5_gated_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> (cmd_q == '0));

  a_r5_gated_ill_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(ill_q));

  a_r9_mrs_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_i && dec_i[CI_MRS] && !banks_idle_i) |=> (cmd_q == '0 && ill_q));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ill_q |=> ill_q);

endmodule

// File: rtl/sdr_cmd_frontend.sv
module sdr_cmd_frontend
  import sdfe_pkg::*;
#(
  parameter int NUM_CMD = CMD_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               ras_n,
  input  logic               cas_n,
  input  logic               we_n,
  input  logic               cke,
  input  logic               banks_idle_i,
  output logic [NUM_CMD-1:0] cmd_o,
  output logic               clk_en_o,
  output logic               freeze_o,
  output logic               pwrdn_o,
  output logic               illegal_o
);

  logic               rst_meta, rst_sync;
  pins_t              pins;
  logic [NUM_CMD-1:0] dec;
  pwr_state_e         pstate;
  logic               accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign pins = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

  sdfe_cmd_decode #(.NUM_CMD(NUM_CMD)) u_decode (
    .pins_i   (pins),
    .onehot_o (dec)
  );

  sdfe_pwr_fsm u_pwr (
    .clk          (clk),
    .rst_n        (rst_sync),
    .cke_i        (cke),
    .banks_idle_i (banks_idle_i),
    .state_o      (pstate)
  );

  assign accept = (pstate == PS_ACTIVE);

  sdfe_cmd_stage #(.NUM_CMD(NUM_CMD)) u_stage (
    .clk          (clk),
    .rst_n        (rst_sync),
    .accept_i     (accept),
    .banks_idle_i (banks_idle_i),
    .dec_i        (dec),
    .cmd_o        (cmd_o),
    .illegal_o    (illegal_o)
  );

  assign clk_en_o = (pstate == PS_ACTIVE);
  assign freeze_o = (pstate != PS_ACTIVE);
  assign pwrdn_o  = (pstate == PS_PDOWN);

  a_r4_freeze_holds: assert property (@(posedge clk) disable iff (!rst_sync)
    (freeze_o && !cke) |=> (freeze_o && !clk_en_o));

  a_r6_pdown_implies_freeze: assert property (@(posedge clk) disable iff (!rst_sync)
    pwrdn_o |-> freeze_o);

endmodule

// File: tb/sdr_cmd_frontend_bench.sv
`timescale 1ns/1ps
module sdr_cmd_frontend_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, ras_n, cas_n, we_n, cke, banks_idle_i;
  logic [7:0] cmd_o;
  logic       clk_en_o, freeze_o, pwrdn_o, illegal_o;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  sdr_cmd_frontend u_sdr_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .cke(cke), .banks_idle_i(banks_idle_i), .cmd_o(cmd_o),
    .clk_en_o(clk_en_o), .freeze_o(freeze_o), .pwrdn_o(pwrdn_o),
    .illegal_o(illegal_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive pins {cs,ras,cas,we}, cke, idle at negedge; return after the next posedge at negedge
  task automatic step(input logic [3:0] p, input logic ck, input logic idle);
    {cs_n, ras_n, cas_n, we_n} = p;
    cke = ck;
    banks_idle_i = idle;
    @(negedge clk);
  endtask

  function automatic logic [7:0] expect_bit(input logic [2:0] s);
    case (s)
      3'b111: return 8'h01;
      3'b011: return 8'h02;
      3'b101: return 8'h04;
      3'b100: return 8'h08;
      3'b010: return 8'h10;
      3'b001: return 8'h20;
      3'b110: return 8'h40;
      default: return 8'h80;
    endcase
  endfunction

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_ACT = 4'b0011;
  localparam logic [3:0] P_RD  = 4'b0101;
  localparam logic [3:0] P_WR  = 4'b0100;
  localparam logic [3:0] P_MRS = 4'b0000;

  task automatic t_reset;
    check("R10 cmd", cmd_o, 8'h00);
    check("R10 flags", {4'b0, clk_en_o, freeze_o, pwrdn_o, illegal_o}, 8'h08);
  endtask

  task automatic t_decode;
    for (int i = 0; i < 8; i++) begin
      step({1'b0, 3'(i)}, 1'b1, 1'b1);
      check("R1 decode", cmd_o, expect_bit(3'(i)));
      check("R3 onehot", 8'($countones(cmd_o)), 8'd1);
    end
    step(4'b1000, 1'b1, 1'b1);
    check("R2 deselect is NOP", cmd_o, 8'h01);
    step(4'b1011, 1'b1, 1'b1);
    check("R2 deselect is NOP", cmd_o, 8'h01);
    step(P_ACT, 1'b1, 1'b0);
    step(P_NOP, 1'b1, 1'b0);
    check("R1 single cycle", cmd_o, 8'h01);
  endtask

  task automatic t_suspend;
    step(P_ACT, 1'b0, 1'b0);
    check("R4 same-edge cmd", cmd_o, 8'h02);
    check("R4 flags", {5'b0, clk_en_o, freeze_o, pwrdn_o}, 8'h02);
    step(P_MRS, 1'b0, 1'b0);
    check("R5 ignored cmd", cmd_o, 8'h00);
    check("R5 no illegal", {7'b0, illegal_o}, 8'h00);
    step(P_RD, 1'b0, 1'b1);
    check("R5 ignored rd", cmd_o, 8'h00);
    check("R4 stays suspend", {5'b0, clk_en_o, freeze_o, pwrdn_o}, 8'h02);
    step(P_RD, 1'b1, 1'b1);
    check("R7 exit edge ignored", cmd_o, 8'h00);
    check("R7 exit flags", {5'b0, clk_en_o, freeze_o, pwrdn_o}, 8'h04);
    step(P_RD, 1'b1, 1'b1);
    check("R7 next accepted", cmd_o, 8'h04);
  endtask

  task automatic t_powerdown;
    step(P_NOP, 1'b0, 1'b1);
    check("R6 enter", {5'b0, clk_en_o, freeze_o, pwrdn_o}, 8'h03);
    check("R6 same-edge NOP", cmd_o, 8'h01);
    step(P_WR, 1'b0, 1'b0);
    check("R6 holds", {5'b0, clk_en_o, freeze_o, pwrdn_o}, 8'h03);
    check("R5 pdown ignored", cmd_o, 8'h00);
    step(P_WR, 1'b1, 1'b1);
    check("R7 pdown exit", {5'b0, clk_en_o, freeze_o, pwrdn_o}, 8'h04);
    check("R7 exit edge ignored", cmd_o, 8'h00);
    step(P_WR, 1'b1, 1'b1);
    check("R7 next accepted", cmd_o, 8'h08);
  endtask

  task automatic t_mrs;
    step(P_MRS, 1'b1, 1'b1);
    check("R8 mrs accepted", cmd_o, 8'h80);
    check("R8 no illegal", {7'b0, illegal_o}, 8'h00);
    step(P_MRS, 1'b1, 1'b0);
    check("R9 mrs dropped", cmd_o, 8'h00);
    check("R9 illegal set", {7'b0, illegal_o}, 8'h01);
    step(P_NOP, 1'b1, 1'b1);
    check("R9 illegal sticky", {7'b0, illegal_o}, 8'h01);
    check("R1 nop after", cmd_o, 8'h01);
  endtask

  task automatic t_reset_again;
    step(P_RD, 1'b1, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R10 cmd cleared", cmd_o, 8'h00);
    check("R10 flags cleared", {4'b0, clk_en_o, freeze_o, pwrdn_o, illegal_o}, 8'h08);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    cke = 1'b1;
    banks_idle_i = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_decode();
    t_suspend();
    t_powerdown();
    t_mrs();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule